// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receive half of a clock-generating synchronous serial port. While a receive is requested it drives a shift clock on `sclk_out` and samples one data bit per clock period from `sdata_in`, least significant bit first. Characters are 8 bits wide, or 9 bits when `nine_en` is set. Each finished character goes into a small receive FIFO. The host reads that FIFO through a register-style port that shows the oldest entry and pops it on a read strobe.

Reception starts in one of two ways. A pulse on `single_req` arms a one-shot enable, which receives exactly one character and then clears itself. The level input `cont_en` instead keeps the clock running character after character. A baud divider sets the shift clock rate, and `clk_pol` selects the idle level of the clock. When a character finishes while the FIFO is full, the block discards that character, raises `overrun` and stops clocking. The host clears this condition by dropping `cont_en` or by dropping `port_en`; dropping `port_en` also resets the whole port.

Top module: `smrx_top`

## Requirements
- R1: After reset and with no receive requested, `sclk_out` sits at its idle level, and `rx_flag`, `irq`, `overrun` and `single_busy` are all 0.
- R2: The idle level of `sclk_out` equals `clk_pol`. Active clocking starts by leaving that level, so `clk_pol`=1 inverts the clock pin.
- R3: Each half period of the shift clock lasts L+1 system clocks. D is `divisor` when `wide_div`=1 and `divisor[7:0]` otherwise. L is D when `hi_speed`=1 and 4*D+3 when `hi_speed`=0.
- R4: Data bits are sampled on the clock edge that returns to the idle level. Bit 0 arrives first, and 8 bits make a character when `nine_en`=0.
- R5: With `nine_en`=1, each character is 9 bits and its last bit appears on `rd_ninth` for the oldest FIFO entry. With `nine_en`=0, `rd_ninth` reads 0.
- R6: A pulse on `single_req` sets `single_busy`. Exactly one character is received, then `single_busy` returns to 0 and the clock stays idle.
- R7: While `cont_en`=1, characters are received back to back. `cont_en` has priority over the one-shot: the clock keeps running after the one-shot clears. Dropping `cont_en` stops the clock and abandons any partial character.
- R8: The FIFO holds two characters in arrival order. `rd_data` and `rd_ninth` show the oldest entry, and `rd_pop` removes it. `rd_pop` has no effect when the FIFO is empty.
- R9: `rx_flag` is 1 exactly while the FIFO is non-empty. `irq` equals `rx_flag` gated by `rx_ie`.
- R10: A character that completes while the FIFO is full is discarded, `overrun` is set, and clocking halts with the stored entries kept intact.
- R11: `overrun` clears when `cont_en` falls. Dropping `port_en` also clears it, and at the same time empties the FIFO and clears `single_busy`.
- R12: While `port_en`=0 the clock stays idle, and both `single_req` and `cont_en` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Port enable; low resets the port |
| cont_en | input | 1 | Continuous receive enable |
| single_req | input | 1 | One-cycle pulse that arms one-character receive |
| nine_en | input | 1 | 9-bit character select |
| clk_pol | input | 1 | Shift clock idle level |
| hi_speed | input | 1 | Divider without x4 prescale |
| wide_div | input | 1 | Use all 16 divisor bits |
| divisor | input | 16 | Baud divisor value |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_pop | input | 1 | Read strobe that pops the FIFO |
| sdata_in | input | 1 | Serial data from the slave |
| sclk_out | output | 1 | Shift clock to the slave |
| rd_data | output | 8 | Low 8 bits of the oldest character |
| rd_ninth | output | 1 | Ninth bit of the oldest character |
| rx_flag | output | 1 | Receive-complete flag (FIFO non-empty) |
| irq | output | 1 | Receive interrupt |
| overrun | output | 1 | Overrun error |
| single_busy | output | 1 | One-shot receive still pending |

## Verification
The hardest situation to reach is overrun. It needs a third character to complete while the two-entry FIFO is full and the host is not reading. The bench gets there by holding `cont_en` high with no pops for three characters. It then confirms that the clock has stopped and the first two entries are intact, and clears the overrun once through a fall of `cont_en` and once through `port_en`. A slave model follows the clock's leading edges and drives the next bit of a prepared character stream. This makes the order of sampling, the 9-bit layout and the divider period visible at the pins.

// File: rtl/smrx_pkg.sv
package smrx_pkg;

   // Shift clock phase: REST is the idle level, DRIVE is the level after the leading edge
   typedef enum logic {
      PH_REST  = 1'b0,
      PH_DRIVE = 1'b1
   } smrx_phase_e;

endpackage

// File: rtl/smrx_baud.sv
module smrx_baud #(
   parameter int DIV_W = 16,
   parameter int LO_W  = 8,
   parameter int PRE_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             hi_speed,
   input  logic             wide_mode,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   localparam int CNT_W = DIV_W + PRE_W;

   if (LO_W > DIV_W || LO_W < 1) begin : g_bad_lo
      $error("smrx_baud: LO_W must lie in 1..DIV_W");
   end

   logic [DIV_W-1:0] div_sel;
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] cnt;

   if (LO_W < DIV_W) begin : g_narrow
      assign div_sel = wide_mode ? divisor
                                 : {{(DIV_W-LO_W){1'b0}}, divisor[LO_W-1:0]};
   end else begin : g_full
      assign div_sel = divisor;
   end

   if (PRE_W > 0) begin : g_pre
      assign limit = hi_speed ? {{PRE_W{1'b0}}, div_sel}
                              : {div_sel, {PRE_W{1'b1}}};
   end else begin : g_nopre
      assign limit = div_sel;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run)     cnt <= '0;
      else if (cnt >= limit)  cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt >= limit);

endmodule

// File: rtl/smrx_shift.sv
module smrx_shift
   import smrx_pkg::*;
#(
   parameter int BASE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic              nine_en,
   input  logic              sdata_in,
   output smrx_phase_e       phase,
   output logic              done,
   output logic [BASE_W:0]   word
);
   localparam int WORD_W = BASE_W + 1;
   localparam int CNT_W  = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] NB_LO = CNT_W'(BASE_W);
   localparam logic [CNT_W-1:0] NB_HI = CNT_W'(WORD_W);

   if (BASE_W < 2) begin : g_bad_w
      $error("smrx_shift: BASE_W must be at least 2");
   end

   logic [CNT_W-1:0]  bitcnt;
   logic [CNT_W-1:0]  nbits;
   logic [WORD_W-1:0] sr;
   logic [WORD_W-1:0] sr_nxt;
   logic              last;

   assign nbits = nine_en ? NB_HI : NB_LO;
   assign last  = (bitcnt == nbits - 1'b1);

   always_comb begin
      sr_nxt = sr;
      sr_nxt[bitcnt] = sdata_in;
   end

   // Leading edge on one tick, sampling edge (back to rest) on the next
   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         phase  <= PH_REST;
         bitcnt <= '0;
         sr     <= '0;
      end else if (tick) begin
         if (phase == PH_REST) begin
            phase <= PH_DRIVE;
         end else begin
            phase <= PH_REST;
            if (last) begin
               bitcnt <= '0;
               sr     <= '0;
            end else begin
               bitcnt <= bitcnt + 1'b1;
               sr     <= sr_nxt;
            end
         end
      end
   end

   assign done = run && tick && (phase == PH_DRIVE) && last;
   assign word = nine_en ? sr_nxt : {1'b0, sr_nxt[BASE_W-1:0]};

   AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt < NB_HI);  // R5

   AST_SAMPLE_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (phase == PH_REST));  // R4

endmodule

// File: rtl/smrx_fifo.sv
module smrx_fifo #(
   parameter int W     = 9,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   if (DEPTH < 1 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("smrx_fifo: DEPTH must be a power of two");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [CNT_W-1:0] count;
   logic             do_push;
   logic             do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CNT_MAX);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);

   if (DEPTH > 1) begin : g_ptr
      always_ff @(posedge clk) begin
         if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
         end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         end
      end
   end else begin : g_single
      assign wr_ptr = '0;
      assign rd_ptr = '0;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) count <= '0;
      else if (do_push && !do_pop) count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
   end

   assign head = mem[rd_ptr];

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_MAX);  // R8

   AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);  // R8

endmodule

// File: rtl/smrx_top.sv
module smrx_top
   import smrx_pkg::*;
#(
   parameter int BASE_W     = 8,
   parameter int DIV_W      = 16,
   parameter int LO_W       = 8,
   parameter int PRE_W      = 2,
   parameter int FIFO_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              cont_en,
   input  logic              single_req,
   input  logic              nine_en,
   input  logic              clk_pol,
   input  logic              hi_speed,
   input  logic              wide_div,
   input  logic [DIV_W-1:0]  divisor,
   input  logic              rx_ie,
   input  logic              rd_pop,
   input  logic              sdata_in,
   output logic              sclk_out,
   output logic [BASE_W-1:0] rd_data,
   output logic              rd_ninth,
   output logic              rx_flag,
   output logic              irq,
   output logic              overrun,
   output logic              single_busy
);
   localparam int WORD_W = BASE_W + 1;

   logic              single_q;
   logic              cont_q;
   logic              ovr_q;
   logic              run;
   logic              tick;
   logic              done;
   smrx_phase_e       phase;
   logic [WORD_W-1:0] word;
   logic [WORD_W-1:0] head;
   logic              empty;
   logic              full;
   logic              pop;
   logic              ovr_set;
   logic              ovr_clr;

   assign run     = port_en && (cont_en || single_q) && !ovr_q;
   assign pop     = rd_pop && port_en && !empty;
   assign ovr_set = done && full && !pop;
   assign ovr_clr = !port_en || (cont_q && !cont_en);

   smrx_baud #(.DIV_W(DIV_W), .LO_W(LO_W), .PRE_W(PRE_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(run), .hi_speed(hi_speed),
      .wide_mode(wide_div), .divisor(divisor), .tick(tick)
   );

   smrx_shift #(.BASE_W(BASE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .nine_en(nine_en),
      .sdata_in(sdata_in), .phase(phase), .done(done), .word(word)
   );

   smrx_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .clear(!port_en), .push(done), .din(word),
      .pop(pop), .head(head), .empty(empty), .full(full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         single_q <= 1'b0;
         cont_q   <= 1'b0;
         ovr_q    <= 1'b0;
      end else begin
         cont_q <= cont_en;
         if (!port_en || done) single_q <= 1'b0;
         else if (single_req)  single_q <= 1'b1;
         if (ovr_clr)      ovr_q <= 1'b0;
         else if (ovr_set) ovr_q <= 1'b1;
      end
   end

   assign sclk_out    = (phase == PH_DRIVE) ^ clk_pol;
   assign rd_data     = head[BASE_W-1:0];
   assign rd_ninth    = head[BASE_W] && !empty;
   assign rx_flag     = !empty;
   assign irq         = rx_flag && rx_ie;
   assign overrun     = ovr_q;
   assign single_busy = single_q;

   AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> $past(full));  // R10

   AST_OVR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && $past(ovr_q)) |-> !done);  // R10

   AST_SINGLE_ENDS_ON_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(single_q) && $past(port_en)) |-> $past(done));  // R6

   AST_PORT_OFF_REST: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (phase == PH_REST));  // R12

   AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> empty);  // R11

endmodule

// File: tb/smrx_top_test.sv
module smrx_top_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        port_en = 1'b0, cont_en = 1'b0, single_req = 1'b0;
   logic        nine_en = 1'b0, clk_pol = 1'b0, hi_speed = 1'b1, wide_div = 1'b0;
   logic [15:0] divisor = 16'h0001;
   logic        rx_ie = 1'b0, rd_pop = 1'b0, sdata_in = 1'b0;
   logic        sclk_out, rd_ninth, rx_flag, irq, overrun, single_busy;
   logic [7:0]  rd_data;

   int n_chk = 0, n_bad = 0;
   int ec = 0;
   int nb = 8;
   logic [8:0] stream [8];
   logic prev_s = 1'b0;
   longint cyc = 0, lt_prev = 0, lt_last = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   smrx_top uut (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .cont_en(cont_en),
      .single_req(single_req), .nine_en(nine_en), .clk_pol(clk_pol),
      .hi_speed(hi_speed), .wide_div(wide_div), .divisor(divisor),
      .rx_ie(rx_ie), .rd_pop(rd_pop), .sdata_in(sdata_in), .sclk_out(sclk_out),
      .rd_data(rd_data), .rd_ninth(rd_ninth), .rx_flag(rx_flag), .irq(irq),
      .overrun(overrun), .single_busy(single_busy)
   );

   // Slave model: on each leading clock edge present the next stream bit
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (prev_s == clk_pol && sclk_out != clk_pol) begin
            sdata_in = stream[(ec / nb) % 8][ec % nb];
            ec++;
            lt_prev = lt_last;
            lt_last = cyc;
         end
         prev_s = sclk_out;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_chars(input int n);
      int t = 0;
      while (ec < n * nb && t < 20000) begin
         @(negedge clk);
         t++;
      end
      while (sclk_out != clk_pol && t < 20000) begin
         @(negedge clk);
         t++;
      end
      cycles(2);
   endtask

   task automatic port_reset();
      cont_en = 1'b0;
      port_en = 1'b0;
      cycles(2);
      port_en = 1'b1;
      ec = 0;
      cycles(1);
   endtask

   task automatic pop_one();
      rd_pop = 1'b1;
      cycles(1);
      rd_pop = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 sclk idle", sclk_out, 1'b0);
      chk("R1 rx_flag", rx_flag, 1'b0);
      chk("R1 irq", irq, 1'b0);
      chk("R1 overrun", overrun, 1'b0);
      chk("R1 single_busy", single_busy, 1'b0);
   endtask

   task automatic t_disabled();
      port_en = 1'b0;
      single_req = 1'b1; cycles(1); single_req = 1'b0;
      cont_en = 1'b1;
      cycles(50);
      chk("R12 no clocking", ec, 0);
      chk("R12 single ignored", single_busy, 1'b0);
      chk("R12 clock idle", sclk_out, clk_pol);
      cont_en = 1'b0;
   endtask

   task automatic t_single();
      port_reset();
      nb = 8; nine_en = 1'b0;
      stream[0] = 9'h1A5;
      single_req = 1'b1; cycles(1); single_req = 1'b0;
      chk("R6 busy set", single_busy, 1'b1);
      wait_chars(1);
      chk("R4 lsb-first data", rd_data, 8'hA5);
      chk("R5 ninth zero in 8-bit", rd_ninth, 1'b0);
      chk("R9 flag set", rx_flag, 1'b1);
      chk("R9 irq masked", irq, 1'b0);
      chk("R6 busy cleared", single_busy, 1'b0);
      cycles(60);
      chk("R6 one char only", ec, 8);
      chk("R6 clock idle", sclk_out, 1'b0);
      rx_ie = 1'b1; cycles(1);
      chk("R9 irq enabled", irq, 1'b1);
      pop_one();
      chk("R9 flag cleared", rx_flag, 1'b0);
      chk("R9 irq cleared", irq, 1'b0);
      pop_one();
      chk("R8 pop on empty", rx_flag, 1'b0);
      rx_ie = 1'b0;
   endtask

   task automatic t_nine();
      port_reset();
      nb = 9; nine_en = 1'b1;
      stream[0] = 9'h13C; stream[1] = 9'h0C3;
      cont_en = 1'b1;
      wait_chars(2);
      cont_en = 1'b0;
      cycles(3);
      chk("R5 ninth bit first", rd_ninth, 1'b1);
      chk("R5 low byte first", rd_data, 8'h3C);
      pop_one();
      chk("R8 second ninth", rd_ninth, 1'b0);
      chk("R8 second data", rd_data, 8'hC3);
      pop_one();
      chk("R8 drained", rx_flag, 1'b0);
      begin
         int e = ec;
         cycles(40);
         chk("R7 stop on cont drop", ec, e);
         chk("R7 clock idle", sclk_out, 1'b0);
      end
      nine_en = 1'b0; nb = 8;
   endtask

   task automatic t_overrun_cont();
      port_reset();
      stream[0] = 9'h011; stream[1] = 9'h022; stream[2] = 9'h033;
      cont_en = 1'b1;
      wait_chars(3);
      chk("R10 overrun set", overrun, 1'b1);
      begin
         int e = ec;
         cycles(80);
         chk("R10 halted", ec, e);
         chk("R10 clock idle", sclk_out, 1'b0);
      end
      chk("R10 first kept", rd_data, 8'h11);
      cont_en = 1'b0;
      cycles(2);
      chk("R11 cleared by cont drop", overrun, 1'b0);
      pop_one();
      chk("R10 second kept", rd_data, 8'h22);
      pop_one();
      chk("R10 third discarded", rx_flag, 1'b0);
   endtask

   task automatic t_both_and_port();
      port_reset();
      stream[0] = 9'h05A; stream[1] = 9'h06B; stream[2] = 9'h07C;
      cont_en = 1'b1;
      single_req = 1'b1; cycles(1); single_req = 1'b0;
      wait_chars(2);
      chk("R7 one-shot cleared", single_busy, 1'b0);
      chk("R7 oldest data", rd_data, 8'h5A);
      wait_chars(3);
      chk("R7 kept clocking", overrun, 1'b1);
      port_en = 1'b0;
      cycles(2);
      chk("R11 port clears overrun", overrun, 1'b0);
      chk("R11 port empties fifo", rx_flag, 1'b0);
      chk("R11 clock idle", sclk_out, 1'b0);
      cont_en = 1'b0;
      port_en = 1'b1;
      cycles(2);
   endtask

   task automatic t_polarity();
      clk_pol = 1'b1;
      cycles(2);
      chk("R2 idle high", sclk_out, 1'b1);
      port_reset();
      stream[0] = 9'h096;
      single_req = 1'b1; cycles(1); single_req = 1'b0;
      wait_chars(1);
      chk("R2 inverted clock data", rd_data, 8'h96);
      chk("R2 rests high", sclk_out, 1'b1);
      pop_one();
      clk_pol = 1'b0;
      port_reset();
   endtask

   task automatic measure(input string req, input longint exp);
      int t = 0;
      port_reset();
      cont_en = 1'b1;
      while (ec < 3 && t < 20000) begin
         @(negedge clk);
         t++;
      end
      chk(req, 32'(lt_last - lt_prev), 32'(exp));
      port_reset();
   endtask

   task automatic t_baud();
      hi_speed = 1'b1; wide_div = 1'b0; divisor = 16'h0102;
      measure("R3 fast narrow", 6);
      hi_speed = 1'b0; divisor = 16'h0101;
      measure("R3 prescaled", 16);
      hi_speed = 1'b1; wide_div = 1'b1; divisor = 16'h0100;
      measure("R3 wide divisor", 514);
      wide_div = 1'b0; divisor = 16'h0001;
   endtask

   initial begin
      for (int i = 0; i < 8; i++) stream[i] = '0;
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
      t_reset();
      t_disabled();
      t_single();
      t_nine();
      t_overrun_cont();
      t_both_and_port();
      t_polarity();
      t_baud();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule